// File: doc/BRIEF.md
# Priority Status LED Blinker

This block drives one status LED from four active-low health signals and a user LED request. Each health signal that reads low is a fault. The block picks the most important fault present and shows it on the LED as a repeating cycle of eight equal time slots. A fault is identified by how many leading slots of the cycle are lit. When every health signal reads high, the LED copies the user request instead.

A built-in prescaler divides the clock into slots of `TICKS_PER_SLOT` cycles. With the default value and a 125 MHz clock, a slot lasts 125 ms and a full cycle lasts one second. The pattern is chosen once, at the start of each eight-slot cycle. A fault that appears or clears part-way through a cycle therefore never cuts short the pattern already on show.

All five inputs pass through a two-flop synchroniser before they are used.

Top module: `status_led_blinker`

## Requirements
- R1: When `power_good` is low, the cycle lights all eight slots, whatever the other inputs are.
- R2: When `power_good` is high and `prog_release` is low, slots 0 to 4 are lit and slots 5 to 7 are dark.
- R3: When the two inputs above are high and `por_release` is low, slots 0 to 3 are lit and slots 4 to 7 are dark.
- R4: When the three inputs above are high and `cfg_done` is low, slots 0 to 2 are lit and slots 3 to 7 are dark.
- R5: When all four health inputs are high, `led_drive` follows the synchronised `user_led` on every clock.
- R6: Each slot lasts exactly `TICKS_PER_SLOT` clocks. The first evaluation happens at the `TICKS_PER_SLOT`-th rising edge after reset is released. Slots then run 0 to 7 and wrap.
- R7: The pattern is selected only at the first evaluation and at the end of slot 7. An input change at any other time has no effect until the next cycle starts.
- R8: Every input passes through two flops. A `user_led` change that is sampled at edge k shows on `led_drive` after edge k+1, and not after edge k.
- R9: While reset is held, and after it until the first evaluation, `led_drive` is low and the slot count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| power_good | input | 1 | Power-good status; low is the top-priority fault |
| prog_release | input | 1 | Programming-request status; low is a fault |
| por_release | input | 1 | Power-on-reset status; low is a fault |
| cfg_done | input | 1 | Configuration-done flag; low is a fault |
| user_led | input | 1 | LED request shown when no fault is present |
| led_drive | output | 1 | LED drive, high means lit |

## Verification
The timing is as follows:
- An input change takes two clocks to reach the selection logic.
- A fault pattern then appears only at the next cycle boundary: at edge `TICKS_PER_SLOT` after reset, and every eight slots after that.
- In the fault-free state, a `user_led` change shows on `led_drive` one edge after the edge that samples it.

The bench drives inputs at falling edges and reads `led_drive` at every falling edge. It compares each reading with a model that counts these same delays itself, so every reading is judged against the cycle in which it is due. Directed checks measure the lit and dark run lengths and the two-edge user delay at their exact edges.

// File: rtl/led_blink_pkg.sv
// Package: shared types and the fault-pattern rules of the status LED blinker.
// Assumes a fixed cycle of eight slots, with lit slots placed first.
package led_blink_pkg;

    localparam int SLOTS  = 8;
    localparam int SLOT_W = $clog2(SLOTS);

    // Pattern currently selected for the LED
    typedef enum logic [2:0] {
        MODE_PWR  = 3'd0,
        MODE_PROG = 3'd1,
        MODE_POR  = 3'd2,
        MODE_DONE = 3'd3,
        MODE_USER = 3'd4
    } mode_e;

    // Fixed priority: the lowest-numbered fault wins
    function automatic mode_e pick_mode(input logic pg, input logic prog,
                                        input logic por, input logic done);
        if (!pg)        return MODE_PWR;
        else if (!prog) return MODE_PROG;
        else if (!por)  return MODE_POR;
        else if (!done) return MODE_DONE;
        else            return MODE_USER;
    endfunction

    // Number of leading slots lit for each fault pattern
    function automatic logic [SLOT_W:0] lit_slots(input mode_e m);
        case (m)
            MODE_PWR:  return (SLOT_W+1)'(8);
            MODE_PROG: return (SLOT_W+1)'(5);
            MODE_POR:  return (SLOT_W+1)'(4);
            MODE_DONE: return (SLOT_W+1)'(3);
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/status_sync.sv
// Module: status_sync
// Two-flop synchroniser for a vector of unrelated, slowly changing inputs.
// Assumes each bit is independent, so no bus coherency is needed.
// Reset loads RST_VAL, which is chosen to read as "healthy".
module status_sync #(
    parameter int               WIDTH   = 5,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage1;

    // Purpose: move each input through two flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            dout   <= RST_VAL;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end

endmodule

// File: rtl/slot_prescaler.sv
// Module: slot_prescaler
// Divides the clock into slots. It pulses `tick` for one clock every
// TICKS_PER_SLOT clocks. Assumes TICKS_PER_SLOT >= 1.
// The first tick comes TICKS_PER_SLOT clocks after reset is released.
module slot_prescaler #(
    parameter int TICKS_PER_SLOT = 15_625_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CNT_W = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SLOT - 1);

    generate
        if (TICKS_PER_SLOT > 1) begin : g_div
            logic [CNT_W-1:0] cnt;

            // Purpose: count clocks within a slot and wrap at the last one.
            always_ff @(posedge clk) begin
                if (!rst_n)          cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                 cnt <= cnt + 1'b1;
            end

            assign tick = (cnt == LAST);

            // Ticks are single-cycle pulses (R6)
            assert_tick_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pattern_sequencer.sv
// Module: pattern_sequencer
// Steps the slot counter 0..7 on every tick. It latches the requested mode
// only at a cycle boundary: the first tick after reset, or the tick that
// ends slot 7. `started` stays low until that first tick.
module pattern_sequencer
    import led_blink_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  mode_e             req_mode,
    output logic              started,
    output mode_e             cur_mode,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic boundary;
    assign boundary = tick && (!started || slot == LAST_SLOT);

    // Purpose: advance the slot on each tick and latch the mode at cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started  <= 1'b0;
            slot     <= '0;
            cur_mode <= MODE_USER;
        end else if (tick) begin
            started <= 1'b1;
            slot    <= started ? slot + 1'b1 : '0;
            if (boundary) cur_mode <= req_mode;
        end
    end

    // Mode holds except at a cycle boundary (R7)
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && (!started || slot == LAST_SLOT)) |=> $stable(cur_mode));
    // Slot moves only on a tick (R6)
    assert_slot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(slot));
    // Slot stays 0 until the first evaluation (R9)
    assert_slot_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> slot == '0);
    // Once running, the sequencer never returns to idle (R9)
    assert_started_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        started |=> started);

endmodule

// File: rtl/status_led_blinker.sv
// Module: status_led_blinker (top)
// Synchronises the health and user inputs and picks the highest-priority
// fault. The chosen pattern is shown over an eight-slot cycle; the user LED
// is shown when no fault is present.
// Assumes the inputs are asynchronous and slow compared with a slot.
module status_led_blinker
    import led_blink_pkg::*;
#(
    parameter int TICKS_PER_SLOT = 15_625_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power_good,
    input  logic prog_release,
    input  logic por_release,
    input  logic cfg_done,
    input  logic user_led,
    output logic led_drive
);

    localparam int IN_W = 5;

    logic [IN_W-1:0]   raw_in, sync_in;
    logic              tick, started;
    logic [SLOT_W-1:0] slot;
    mode_e             req_mode, cur_mode;

    assign raw_in = {user_led, cfg_done, por_release, prog_release, power_good};

    status_sync #(.WIDTH(IN_W), .RST_VAL(5'b01111)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(sync_in)
    );

    slot_prescaler #(.TICKS_PER_SLOT(TICKS_PER_SLOT)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    assign req_mode = pick_mode(sync_in[0], sync_in[1], sync_in[2], sync_in[3]);

    pattern_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req_mode(req_mode),
        .started(started), .cur_mode(cur_mode), .slot(slot)
    );

    // Purpose: turn the latched mode and the slot into the LED level.
    always_comb begin
        if (!started)                    led_drive = 1'b0;
        else if (cur_mode == MODE_USER)  led_drive = sync_in[4];
        else                             led_drive = ({1'b0, slot} < lit_slots(cur_mode));
    end

    // LED dark before the first evaluation (R9)
    assert_dark_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> !led_drive);
    // Power fault keeps the LED solidly lit (R1)
    assert_power_solid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (started && cur_mode == MODE_PWR) |-> led_drive);
    // A new power fault is latched at the very next boundary (R1)
    assert_power_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (!started || slot == SLOT_W'(SLOTS - 1)) && !sync_in[0])
        |=> cur_mode == MODE_PWR);

endmodule

// File: tb/tb_status_led_blinker.sv
module tb_status_led_blinker;

    localparam int P = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg = 1'b1, prog = 1'b1, por = 1'b1, done = 1'b1, usr = 1'b0;
    logic led;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    status_led_blinker #(.TICKS_PER_SLOT(P)) dut (
        .clk(clk), .rst_n(rst_n), .power_good(pg), .prog_release(prog),
        .por_release(por), .cfg_done(done), .user_led(usr), .led_drive(led)
    );

    // Reference model, written from the requirements
    logic [4:0] m_d1, m_d2;   // {usr,done,por,prog,pg}
    int m_pc, m_slot, m_mode; // mode: 0 pwr,1 prog,2 por,3 done,4 user
    bit m_started;

    function automatic int sel_mode(input logic [4:0] s);
        if (!s[0]) return 0;
        if (!s[1]) return 1;
        if (!s[2]) return 2;
        if (!s[3]) return 3;
        return 4;
    endfunction

    function automatic int lit_of(input int m);
        case (m)
            0: return 8;
            1: return 5;
            2: return 4;
            3: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic exp_led();
        if (!m_started) return 1'b0;
        if (m_mode == 4) return m_d2[4];
        return (m_slot < lit_of(m_mode));
    endfunction

    function automatic string tag_of();
        if (!m_started) return "R9";
        if (m_mode != sel_mode(m_d2)) return "R7";
        case (m_mode)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_d1 <= 5'b01111; m_d2 <= 5'b01111;
            m_pc <= 0; m_slot <= 0; m_mode <= 4; m_started <= 1'b0;
        end else begin
            m_d1 <= {usr, done, por, prog, pg};
            m_d2 <= m_d1;
            if (m_pc == P - 1) begin
                m_pc <= 0;
                if (!m_started) begin
                    m_started <= 1'b1; m_slot <= 0; m_mode <= sel_mode(m_d2);
                end else begin
                    m_slot <= (m_slot + 1) % 8;
                    if (m_slot == 7) m_mode <= sel_mode(m_d2);
                end
            end else begin
                m_pc <= m_pc + 1;
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare with the model at every falling edge
    always @(negedge clk) begin
        if (model_on) check(tag_of(), led, exp_led());
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R9", led, 1'b0);
        rst_n = 1'b1;
    endtask

    int run;

    initial begin
        void'($urandom(32'd1234));
        // Directed: reset state with a power fault present (R9, R1)
        pg = 1'b0;
        do_reset();
        model_on = 1'b1;
        repeat (P - 1) begin
            @(negedge clk);
            check("R9", led, 1'b0);   // dark until first evaluation
        end
        @(negedge clk);
        check("R1", led, 1'b1);

        // Directed: slot lengths under a programming fault (R6, R2)
        pg = 1'b1; prog = 1'b0;
        model_on = 1'b0;
        do_reset();
        model_on = 1'b1;
        while (!led) @(negedge clk);
        run = 0;
        while (led) begin run++; @(negedge clk); end
        check("R6", (run == 5 * P), 1'b1);
        if (run != 5 * P) $display("FAIL R6 lit run actual=%0d expected=%0d", run, 5 * P);
        run = 0;
        while (!led) begin run++; @(negedge clk); end
        check("R6", (run == 3 * P), 1'b1);
        if (run != 3 * P) $display("FAIL R6 dark run actual=%0d expected=%0d", run, 3 * P);

        // Directed: two-flop latency of the user LED (R8, R5)
        prog = 1'b1; usr = 1'b0;
        repeat (3 * 8 * P) @(negedge clk);
        usr = 1'b1;
        @(negedge clk);
        check("R8", led, 1'b0);
        @(negedge clk);
        check("R8", led, 1'b1);

        // Random phase: the model judges every cycle (R1-related tags inside)
        for (int i = 0; i < 400; i++) begin
            repeat (1 + ($urandom % 60)) @(negedge clk);
            pg   = ($urandom % 10) != 0;
            prog = ($urandom % 5) != 0;
            por  = ($urandom % 5) != 0;
            done = ($urandom % 4) != 0;
            usr  = $urandom % 2;
        end
        repeat (8 * P) @(negedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule